// File: doc/BRIEF.md
# Vector Operand Fetch with Swizzle, Sign Modifiers and Masked Write-Back

This block is the operand path of a four-lane vector shader datapath. Each register is a 128-bit vector of four 32-bit single-precision lanes. Up to three source operands are fetched in parallel from an input bank, a temporary bank or a constant bank. A constant may also be addressed relative to a signed address register. Each operand is then rearranged lane by lane through its own swizzle. After that, its sign bits are altered by absolute-value and negate controls, and the result goes straight to the arithmetic unit, which lies outside this block.

On the return side, a result from the arithmetic unit is written into the temporary bank. A per-lane mask selects which lanes change. A scalar result is first copied to every lane and then masked. The input and constant banks are filled through plain write ports by the surrounding pipeline, before the vertex work that reads them. Operand reads are combinational, and result writes take effect at the next rising clock edge.

Top module: `vec_operand_path`

## Requirements
- R1: Lane c of a vector occupies bits [32c+31:32c] (x = lane 0 at bits 31:0, w = lane 3). Swizzle field bits [2c+1:2c] name the source lane for output lane c, with 0=x, 1=y, 2=z, 3=w, so 8'hE4 is the identity and repeated codes replicate a lane.
- R2: The bank code of an operand is 0 for input, 1 for temporary, 2 for constant and 3 for an all-zero vector. A direct index at or beyond the depth of the chosen bank yields an all-zero vector.
- R3: When the relative flag is set and the bank is constant, the entry read is the signed address register plus the unsigned 8-bit index. A sum below 0 or above 255 yields (0,0,0,0). The relative flag has no effect on the other banks.
- R4: Modifiers act after the swizzle and on bit 31 of each lane only. Absolute value clears it and negate inverts it, and absolute value is applied before negate when both are set.
- R5: The three operands are independent: the same register may feed several operands in one cycle, each with its own swizzle and modifiers.
- R6: A result write updates temporary lane c only when mask bit c is 1; the other lanes keep their previous contents. With the write enable low, nothing changes.
- R7: With the scalar flag set, lane 0 of the result is copied to all four lanes before the mask is applied.
- R8: A written temporary is visible from the cycle after the write edge; a read in the write cycle returns the old value.
- R9: Reset clears every entry of all three banks to zero.
- R10: The input and constant write ports store a full 128-bit vector at the addressed entry, readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we | input | 1 | Input bank write enable |
| in_waddr | input | 8 | Input bank write entry |
| in_wdata | input | 128 | Input bank write vector |
| cst_we | input | 1 | Constant bank write enable |
| cst_waddr | input | 8 | Constant bank write entry |
| cst_wdata | input | 128 | Constant bank write vector |
| addr_reg | input | 10 | Signed address register for relative constant reads |
| op_bank | input | 6 | Bank code per operand, 2 bits each, operand k at [2k+1:2k] |
| op_idx | input | 24 | Entry index or relative offset per operand, 8 bits each |
| op_rel | input | 3 | Relative-addressing flag per operand |
| op_swz | input | 24 | Swizzle per operand, 8 bits each |
| op_neg | input | 3 | Negate flag per operand |
| op_abs | input | 3 | Absolute-value flag per operand |
| op_data | output | 384 | Modified operands, 128 bits each, operand k at [128k+127:128k] |
| res_we | input | 1 | Result write enable |
| res_dst | input | 8 | Temporary entry to write |
| res_mask | input | 4 | Per-lane write mask |
| res_scalar | input | 1 | Broadcast lane 0 of the result |
| res_data | input | 128 | Result vector |

## Verification
The hardest case to reach is a relative constant read whose sum straddles either end of the bank, where a fault in sign extension or wrap-around would alias onto a valid entry. The stimulus sweeps the address register across negative and positive values around both limits, with offsets of 0, 13, 200 and 255. Every constant entry is loaded with a distinct pattern, so any aliased read shows up. Masked writes are checked by first filling the target with a known vector, then writing every mask with and without broadcast, so both kept and replaced lanes are compared.

// File: rtl/vec_pkg.sv
package vec_pkg;
   typedef enum logic [1:0] {
      BANK_IN   = 2'd0,
      BANK_TMP  = 2'd1,
      BANK_CST  = 2'd2,
      BANK_ZERO = 2'd3
   } bank_e;
endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
   parameter int DEPTH = 16,
   parameter int LANES = 4,
   parameter int LW    = 32,
   parameter int NRD   = 3,
   parameter int IDX_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       waddr,
   input  logic [LANES-1:0]       lane_en,
   input  logic [LANES*LW-1:0]    wdata,
   input  logic [NRD*IDX_W-1:0]   rd_idx,
   output logic [NRD*LANES*LW-1:0] rd_data
);
   localparam int VW = LANES * LW;
   localparam int AW = $clog2(DEPTH);
   localparam logic [IDX_W:0] DEPTH_L = (IDX_W + 1)'(DEPTH);

   if (DEPTH < 2 || DEPTH > (1 << IDX_W)) begin : g_bad_depth
      $error("vec_regfile: DEPTH must lie in 2..2**IDX_W");
   end

   logic [VW-1:0] mem [DEPTH];
   logic          w_ok;
   logic [AW-1:0] w_at;
   logic [VW-1:0] cur_word;

   assign w_ok = ({1'b0, waddr} < DEPTH_L);
   assign w_at = waddr[AW-1:0];
   assign cur_word = w_ok ? mem[w_at] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && w_ok) begin
         for (int c = 0; c < LANES; c++)
            if (lane_en[c]) mem[w_at][c*LW +: LW] <= wdata[c*LW +: LW];
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      logic [IDX_W-1:0] ri;
      logic             r_ok;
      assign ri   = rd_idx[r*IDX_W +: IDX_W];
      assign r_ok = ({1'b0, ri} < DEPTH_L);
      assign rd_data[r*VW +: VW] = r_ok ? mem[ri[AW-1:0]] : '0;
   end

   for (genvar c = 0; c < LANES; c++) begin : g_lane_chk
      // R6: lanes outside the mask hold their contents
      a_r6_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (we && w_ok && !lane_en[c]) |=>
            mem[$past(w_at)][c*LW +: LW] == $past(cur_word[c*LW +: LW]));
      // R6: lanes inside the mask take the new data
      a_r6_lane_written: assert property (@(posedge clk) disable iff (!rst_n)
         (we && w_ok && lane_en[c]) |=>
            mem[$past(w_at)][c*LW +: LW] == $past(wdata[c*LW +: LW]));
   end
endmodule

// File: rtl/vec_cidx.sv
module vec_cidx #(
   parameter int DEPTH = 256,
   parameter int AR_W  = 10,
   parameter int IDX_W = 8
) (
   input  logic signed [AR_W-1:0] base,
   input  logic [IDX_W-1:0]       offset,
   output logic [IDX_W-1:0]       idx,
   output logic                   oob
);
   localparam int SW = ((AR_W > IDX_W) ? AR_W : IDX_W + 1) + 1;

   if (AR_W < 2 || DEPTH > (1 << IDX_W)) begin : g_bad_cfg
      $error("vec_cidx: illegal index configuration");
   end

   logic signed [SW-1:0] sum;
   assign sum = $signed({{(SW-AR_W){base[AR_W-1]}}, base})
              + $signed({{(SW-IDX_W){1'b0}}, offset});
   assign oob = (sum < 0) || (sum >= SW'(DEPTH));
   assign idx = sum[IDX_W-1:0];
endmodule

// File: rtl/vec_src_mod.sv
module vec_src_mod #(
   parameter int LANES = 4,
   parameter int LW    = 32
) (
   input  logic [LANES*LW-1:0]          vin,
   input  logic [LANES*$clog2(LANES)-1:0] swz,
   input  logic                         neg,
   input  logic                         abs_en,
   output logic [LANES*LW-1:0]          vout
);
   localparam int SEL_W = $clog2(LANES);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0 || LW < 2) begin : g_bad_cfg
      $error("vec_src_mod: LANES must be a power of two, LW at least 2");
   end

   for (genvar c = 0; c < LANES; c++) begin : g_lane
      logic [SEL_W-1:0] sel;
      logic [LW-1:0]    picked;
      logic [LW-1:0]    mag;
      assign sel    = swz[c*SEL_W +: SEL_W];
      assign picked = vin[sel*LW +: LW];
      assign mag    = abs_en ? {1'b0, picked[LW-2:0]} : picked;
      assign vout[c*LW +: LW] = neg ? {~mag[LW-1], mag[LW-2:0]} : mag;
   end
endmodule

// File: rtl/vec_wr_merge.sv
module vec_wr_merge #(
   parameter int LANES = 4,
   parameter int LW    = 32
) (
   input  logic [LANES*LW-1:0] res,
   input  logic                scalar,
   input  logic [LANES-1:0]    mask,
   output logic [LANES*LW-1:0] wdata,
   output logic [LANES-1:0]    lane_en
);
   for (genvar c = 0; c < LANES; c++) begin : g_lane
      assign wdata[c*LW +: LW] = scalar ? res[LW-1:0] : res[c*LW +: LW];
   end
   assign lane_en = mask;
endmodule

// File: rtl/vec_operand_path.sv
module vec_operand_path
   import vec_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int LW        = 32,
   parameter int NOPS      = 3,
   parameter int IN_DEPTH  = 16,
   parameter int TMP_DEPTH = 16,
   parameter int CST_DEPTH = 256,
   parameter int IDX_W     = 8,
   parameter int AR_W      = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_we,
   input  logic [IDX_W-1:0]              in_waddr,
   input  logic [LANES*LW-1:0]           in_wdata,
   input  logic                          cst_we,
   input  logic [IDX_W-1:0]              cst_waddr,
   input  logic [LANES*LW-1:0]           cst_wdata,
   input  logic signed [AR_W-1:0]        addr_reg,
   input  logic [NOPS*2-1:0]             op_bank,
   input  logic [NOPS*IDX_W-1:0]         op_idx,
   input  logic [NOPS-1:0]               op_rel,
   input  logic [NOPS*LANES*$clog2(LANES)-1:0] op_swz,
   input  logic [NOPS-1:0]               op_neg,
   input  logic [NOPS-1:0]               op_abs,
   output logic [NOPS*LANES*LW-1:0]      op_data,
   input  logic                          res_we,
   input  logic [IDX_W-1:0]              res_dst,
   input  logic [LANES-1:0]              res_mask,
   input  logic                          res_scalar,
   input  logic [LANES*LW-1:0]           res_data
);
   localparam int VW    = LANES * LW;
   localparam int SWZ_W = LANES * $clog2(LANES);

   if (NOPS < 1) begin : g_bad_nops
      $error("vec_operand_path: NOPS must be at least 1");
   end

   logic [NOPS*IDX_W-1:0] in_ridx, tmp_ridx, cst_ridx;
   logic [NOPS*VW-1:0]    in_rdat, tmp_rdat, cst_rdat;
   logic [VW-1:0]         t_wdata;
   logic [LANES-1:0]      t_lane_en;

   vec_regfile #(.DEPTH(IN_DEPTH), .LANES(LANES), .LW(LW), .NRD(NOPS), .IDX_W(IDX_W)) u_in_bank (
      .clk(clk), .rst_n(rst_n), .we(in_we), .waddr(in_waddr), .lane_en({LANES{1'b1}}),
      .wdata(in_wdata), .rd_idx(in_ridx), .rd_data(in_rdat));

   vec_regfile #(.DEPTH(CST_DEPTH), .LANES(LANES), .LW(LW), .NRD(NOPS), .IDX_W(IDX_W)) u_cst_bank (
      .clk(clk), .rst_n(rst_n), .we(cst_we), .waddr(cst_waddr), .lane_en({LANES{1'b1}}),
      .wdata(cst_wdata), .rd_idx(cst_ridx), .rd_data(cst_rdat));

   vec_wr_merge #(.LANES(LANES), .LW(LW)) u_merge (
      .res(res_data), .scalar(res_scalar), .mask(res_mask),
      .wdata(t_wdata), .lane_en(t_lane_en));

   vec_regfile #(.DEPTH(TMP_DEPTH), .LANES(LANES), .LW(LW), .NRD(NOPS), .IDX_W(IDX_W)) u_tmp_bank (
      .clk(clk), .rst_n(rst_n), .we(res_we), .waddr(res_dst), .lane_en(t_lane_en),
      .wdata(t_wdata), .rd_idx(tmp_ridx), .rd_data(tmp_rdat));

   for (genvar k = 0; k < NOPS; k++) begin : g_op
      bank_e            bank;
      logic [IDX_W-1:0] idx_k;
      logic             rel_k;
      logic [IDX_W-1:0] c_idx;
      logic             c_oob;
      logic [VW-1:0]    raw;
      logic [VW-1:0]    vout;

      assign bank  = bank_e'(op_bank[k*2 +: 2]);
      assign idx_k = op_idx[k*IDX_W +: IDX_W];
      assign rel_k = op_rel[k];

      vec_cidx #(.DEPTH(CST_DEPTH), .AR_W(AR_W), .IDX_W(IDX_W)) u_cidx (
         .base(addr_reg), .offset(idx_k), .idx(c_idx), .oob(c_oob));

      assign in_ridx[k*IDX_W +: IDX_W]  = idx_k;
      assign tmp_ridx[k*IDX_W +: IDX_W] = idx_k;
      assign cst_ridx[k*IDX_W +: IDX_W] = rel_k ? c_idx : idx_k;

      always_comb begin
         case (bank)
            BANK_IN:  raw = in_rdat[k*VW +: VW];
            BANK_TMP: raw = tmp_rdat[k*VW +: VW];
            BANK_CST: raw = (rel_k && c_oob) ? '0 : cst_rdat[k*VW +: VW];
            default:  raw = '0;
         endcase
      end

      vec_src_mod #(.LANES(LANES), .LW(LW)) u_mod (
         .vin(raw), .swz(op_swz[k*SWZ_W +: SWZ_W]), .neg(op_neg[k]),
         .abs_en(op_abs[k]), .vout(vout));

      assign op_data[k*VW +: VW] = vout;

      // R3: relative constant read outside the bank delivers zero before modifiers
      a_r3_rel_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (bank == BANK_CST && rel_k &&
          ((int'(addr_reg) + int'(idx_k)) < 0 || (int'(addr_reg) + int'(idx_k)) >= CST_DEPTH))
         |-> raw == '0);

      // R2: the zero bank code yields zero before modifiers
      a_r2_zero_bank: assert property (@(posedge clk) disable iff (!rst_n)
         (bank == BANK_ZERO) |-> raw == '0);

      for (genvar c = 0; c < LANES; c++) begin : g_sign
         // R4: absolute value alone leaves every sign bit clear
         a_r4_abs_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (op_abs[k] && !op_neg[k]) |-> !vout[c*LW + LW - 1]);
         // R4: absolute value then negate leaves every sign bit set
         a_r4_abs_then_neg: assert property (@(posedge clk) disable iff (!rst_n)
            (op_abs[k] && op_neg[k]) |-> vout[c*LW + LW - 1]);
      end
   end
endmodule

// File: tb/tb_vec_operand_path.sv
module tb_vec_operand_path;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic               in_we, cst_we, res_we, res_scalar;
   logic [7:0]         in_waddr, cst_waddr, res_dst;
   logic [127:0]       in_wdata, cst_wdata, res_data;
   logic signed [9:0]  addr_reg;
   logic [5:0]         op_bank;
   logic [23:0]        op_idx, op_swz;
   logic [2:0]         op_rel, op_neg, op_abs;
   logic [383:0]       op_data;
   logic [3:0]         res_mask;

   vec_operand_path dut (
      .clk(clk), .rst_n(rst_n),
      .in_we(in_we), .in_waddr(in_waddr), .in_wdata(in_wdata),
      .cst_we(cst_we), .cst_waddr(cst_waddr), .cst_wdata(cst_wdata),
      .addr_reg(addr_reg), .op_bank(op_bank), .op_idx(op_idx), .op_rel(op_rel),
      .op_swz(op_swz), .op_neg(op_neg), .op_abs(op_abs), .op_data(op_data),
      .res_we(res_we), .res_dst(res_dst), .res_mask(res_mask),
      .res_scalar(res_scalar), .res_data(res_data));

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [127:0] in_m  [16];
   logic [127:0] tmp_m [16];
   logic [127:0] cst_m [256];

   function automatic logic [31:0] lane_of(logic [127:0] v, int s);
      return 32'((v >> (32 * s)) & 128'hFFFF_FFFF);
   endfunction

   function automatic logic [31:0] pin(int i, int c);
      logic [31:0] v = 32'h4000_0000 + 32'(i << 12) + 32'(c << 4) + 1;
      if ((i + c) % 3 == 0) v = v | 32'h8000_0000;
      return v;
   endfunction

   function automatic logic [31:0] pcs(int i, int c);
      logic [31:0] v = 32'h3E00_0000 ^ 32'(i << 9) ^ 32'(c << 2);
      if (((i ^ c) & 1) == 1) v = v | 32'h8000_0000;
      return v;
   endfunction

   function automatic logic [127:0] modify(logic [127:0] v, logic [7:0] swz, bit neg, bit ab);
      logic [127:0] r = '0;
      for (int c = 0; c < 4; c++) begin
         int s = (swz >> (2 * c)) & 3;
         logic [31:0] x = lane_of(v, s);
         if (ab) x = x & 32'h7FFF_FFFF;
         if (neg) x = x ^ 32'h8000_0000;
         r = r | (128'(x) << (32 * c));
      end
      return r;
   endfunction

   function automatic logic [127:0] fetch(int bank, int idx, bit rel, int ar);
      if (bank == 0) return (idx < 16) ? in_m[idx] : '0;
      if (bank == 1) return (idx < 16) ? tmp_m[idx] : '0;
      if (bank == 2) begin
         int e = rel ? ar + idx : idx;
         return (e < 0 || e > 255) ? '0 : cst_m[e];
      end
      return '0;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_op(int k, int bank, int idx, bit rel, logic [7:0] swz, bit neg, bit ab);
      op_bank[k*2 +: 2]  = 2'(bank);
      op_idx[k*8 +: 8]   = 8'(idx);
      op_rel[k]          = rel;
      op_swz[k*8 +: 8]   = swz;
      op_neg[k]          = neg;
      op_abs[k]          = ab;
   endtask

   task automatic chk_op(string req, int k, int bank, int idx, bit rel, logic [7:0] swz, bit neg, bit ab);
      chk(req, op_data[k*128 +: 128], modify(fetch(bank, idx, rel, int'(addr_reg)), swz, neg, ab));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      in_we = 0; cst_we = 0; res_we = 0; res_scalar = 0;
      in_waddr = 0; cst_waddr = 0; res_dst = 0; res_mask = 0;
      in_wdata = 0; cst_wdata = 0; res_data = 0; addr_reg = 0;
      op_bank = 0; op_idx = 0; op_rel = 0; op_swz = 0; op_neg = 0; op_abs = 0;
      for (int i = 0; i < 16; i++) begin in_m[i] = '0; tmp_m[i] = '0; end
      for (int i = 0; i < 256; i++) cst_m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: every bank reads zero after reset
      @(negedge clk);
      set_op(0, 0, 5, 0, 8'hE4, 0, 0);
      set_op(1, 1, 3, 0, 8'hE4, 0, 0);
      set_op(2, 2, 200, 0, 8'hE4, 0, 0);
      #1;
      chk("R9 input bank after reset", op_data[127:0], '0);
      chk("R9 temp bank after reset", op_data[255:128], '0);
      chk("R9 const bank after reset", op_data[383:256], '0);

      // R10: fill input and constant banks
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         in_we = (i < 16); in_waddr = 8'(i); cst_we = 1; cst_waddr = 8'(i);
         for (int c = 0; c < 4; c++) begin
            in_wdata[c*32 +: 32]  = pin(i, c);
            cst_wdata[c*32 +: 32] = pcs(i, c);
         end
         if (i < 16) in_m[i] = in_wdata;
         cst_m[i] = cst_wdata;
      end
      @(negedge clk);
      in_we = 0; cst_we = 0;

      // R10: identity reads of loaded entries
      for (int i = 0; i < 16; i++) begin
         set_op(0, 0, i, 0, 8'hE4, 0, 0);
         set_op(1, 2, i * 17, 0, 8'hE4, 0, 0);
         #1;
         chk_op("R10 input load", 0, 0, i, 0, 8'hE4, 0, 0);
         chk_op("R10 const load", 1, 2, i * 17, 0, 8'hE4, 0, 0);
         @(negedge clk);
      end

      // R1 R4 R5: full swizzle and modifier sweep, same register on several operands
      for (int b = 0; b < 2; b++) begin
         int bank = (b == 0) ? 0 : 2;
         int idx  = (b == 0) ? 3 : 77;
         for (int s = 0; s < 256; s++) begin
            for (int m = 0; m < 4; m++) begin
               set_op(0, bank, idx, 0, 8'(s), m[0], m[1]);
               set_op(1, bank, idx, 0, 8'(s ^ 8'hFF), ~m[0], ~m[1]);
               set_op(2, 0, (s % 16), 0, 8'(255 - s), m[1], m[0]);
               #1;
               chk_op("R1 R4 swizzle and modifiers op0", 0, bank, idx, 0, 8'(s), m[0], m[1]);
               chk_op("R5 same register op1", 1, bank, idx, 0, 8'(s ^ 8'hFF), ~m[0], ~m[1]);
               chk_op("R5 independent op2", 2, 0, (s % 16), 0, 8'(255 - s), m[1], m[0]);
               #2;
            end
         end
      end

      // R3: relative constant reads across both limits
      for (int ar = -300; ar <= 300; ar += 7) begin
         for (int o = 0; o < 4; o++) begin
            int off = (o == 0) ? 0 : (o == 1) ? 13 : (o == 2) ? 200 : 255;
            addr_reg = 10'(ar);
            set_op(0, 2, off, 1, 8'hE4, 0, 0);
            set_op(1, 0, off % 16, 1, 8'hE4, 0, 0);
            set_op(2, 2, off, 1, 8'h1B, 1, 0);
            #1;
            chk_op("R3 relative const read", 0, 2, off, 1, 8'hE4, 0, 0);
            chk_op("R3 relative flag ignored on input", 1, 0, off % 16, 1, 8'hE4, 0, 0);
            chk_op("R3 relative with modifiers", 2, 2, off, 1, 8'h1B, 1, 0);
            #2;
         end
      end
      // R3: exact edges
      for (int e = 0; e < 4; e++) begin
         int ar  = (e == 0) ? -1 : (e == 1) ? 0 : (e == 2) ? 1 : -255;
         int off = (e == 0) ? 0 : (e == 1) ? 255 : (e == 2) ? 255 : 0;
         addr_reg = 10'(ar);
         set_op(0, 2, off, 1, 8'hE4, 0, 0);
         #1;
         chk_op("R3 edge", 0, 2, off, 1, 8'hE4, 0, 0);
         #2;
      end
      addr_reg = 0;

      // R2: zero bank and indexes beyond depth
      set_op(0, 3, 4, 0, 8'hE4, 1, 0);
      set_op(1, 0, 16, 0, 8'hE4, 0, 0);
      set_op(2, 1, 200, 0, 8'hE4, 0, 0);
      #1;
      chk("R2 zero bank negated", op_data[127:0], {4{32'h8000_0000}});
      chk("R2 input index beyond depth", op_data[255:128], '0);
      chk("R2 temp index beyond depth", op_data[383:256], '0);

      // R6 R7 R8: masked and broadcast writes
      for (int sc = 0; sc < 2; sc++) begin
         for (int mk = 0; mk < 16; mk++) begin
            logic [127:0] p, q, x;
            int t = mk;
            for (int c = 0; c < 4; c++) begin
               p[c*32 +: 32] = 32'h1100_0000 + 32'(mk << 8) + 32'(c);
               q[c*32 +: 32] = 32'hA200_0000 + 32'(sc << 12) + 32'(mk << 4) + 32'(c);
            end
            @(negedge clk);
            res_we = 1; res_dst = 8'(t); res_mask = 4'hF; res_scalar = 0; res_data = p;
            @(negedge clk);
            tmp_m[t] = p;
            res_mask = 4'(mk); res_scalar = sc[0]; res_data = q;
            set_op(0, 1, t, 0, 8'hE4, 0, 0);
            #1;
            chk_op("R8 old value in write cycle", 0, 1, t, 0, 8'hE4, 0, 0);
            @(negedge clk);
            res_we = 0;
            x = p;
            for (int c = 0; c < 4; c++)
               if (mk[c]) x[c*32 +: 32] = sc ? q[31:0] : q[c*32 +: 32];
            tmp_m[t] = x;
            #1;
            chk(sc ? "R7 broadcast masked write" : "R6 masked write", op_data[127:0], x);
         end
      end

      // R6: write enable low changes nothing
      @(negedge clk);
      res_we = 0; res_dst = 8'd5; res_mask = 4'hF; res_data = {4{32'hDEAD_BEEF}};
      @(negedge clk);
      set_op(0, 1, 5, 0, 8'hE4, 0, 0);
      #1;
      chk_op("R6 no write when disabled", 0, 1, 5, 0, 8'hE4, 0, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule